// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Sensing

This block is one bank of up to 32 general-purpose I/O pins controlled through a small register bus with a byte address, a write enable, a write data word and a combinational read data word. Software sets the values to drive in an output latch and picks the pins to drive in a direction register. The block drives the pads through plain output and output-enable vectors. The pad inputs pass through a synchronizer of at least two flops before the rest of the block uses them.

Each pin has an interrupt enable, a three-bit sense code and a sticky status bit. The three bits of the code sit in three separate registers. The sense can be a falling edge, a rising edge, both edges, a low level or a high level. Software clears a status bit by writing 1 to it. The single interrupt output is high while any enabled pin has its status bit set.

The value register returns the synchronized pad state and not the latch, so a separate read-only register returns the latch contents.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the output latch, direction, interrupt enable, the three sense registers and status all read 0. `pad_oe` is 0 and `irq` is 0.
- R2: Writing the value register (offset 0x00) loads the output latch, and `pad_out` shows the new value after that clock edge. The latch readback register (offset 0x1C) returns the latch. Writes to offset 0x1C change neither the latch nor `pad_out`.
- R3: The direction register (offset 0x04) drives `pad_oe`. Bit n set to 1 makes pin n an output and 0 makes it an input. The register reads back what was written.
- R4: Reading the value register returns `pad_in` after the two-flop synchronizer. A change on `pad_in` is not visible one clock edge later and is visible after two edges, whatever the direction of the pin.
- R5: The sense code of pin n is {bit n of sense2 at 0x14, bit n of sense1 at 0x10, bit n of sense0 at 0x0C}. When sense1 is 0 the sense is an edge: 000 is a falling edge, 001 a rising edge, and codes 101 and 100 are both edges. An edge is a difference between the current synchronized sample and the previous one. The enable (0x08) and sense registers read back what was written.
- R6: When sense1 is 1 the sense is a level: sense0 = 1 is a high level and 0 a low level, and sense2 is ignored. A level status bit is set again on every cycle the level holds, so a clear write does not remove it while the level stays active.
- R7: A status bit is set only while its enable bit is 1. Clearing the enable keeps a status bit that is already set.
- R8: Status (0x18) is write-1-to-clear. A write clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R9: `irq` is the OR over all pins of status AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NPINS (32) | Pad input levels, asynchronous |
| pad_out | output | NPINS (32) | Output latch driven to the pads |
| pad_oe | output | NPINS (32) | Pad output enables (direction) |
| irq | output | 1 | Combined interrupt |

## Verification
The sense logic is swept over all five named sense codes. Each code is tried with three pad transitions: all pins rising, all pins falling, and a mixed word in which some bits rise, some fall and some stay. Each transition is paired with a different enable mask. The transitions separate rising from falling from both-edge detection, and the stay-constant bits separate edges from levels. A bench model computes the expected status before and after a clear. A final mixed case gives each pin its own code, including the codes that have no name. The bench also measures the synchronizer delay on the value register. It checks partial write-1-to-clear, a write of 0 to status, and that clearing the enable masks `irq` but keeps status.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int unsigned BUS_W = 32;

   // register byte offsets: value at +0 and direction at +4, interrupt group from +0x08
   localparam logic [7:0] OFS_VALUE  = 8'h00;
   localparam logic [7:0] OFS_DIR    = 8'h04;
   localparam logic [7:0] OFS_IEN    = 8'h08;
   localparam logic [7:0] OFS_SENSE0 = 8'h0C;
   localparam logic [7:0] OFS_SENSE1 = 8'h10;
   localparam logic [7:0] OFS_SENSE2 = 8'h14;
   localparam logic [7:0] OFS_ISTAT  = 8'h18;
   localparam logic [7:0] OFS_LATCH  = 8'h1C;

   typedef struct packed {
      logic s2;
      logic s1;
      logic s0;
   } sense_t;

   // condition seen on one pin for its sense code
   function automatic logic sense_hit(sense_t code, logic cur, logic prv);
      if (code.s1)
         return code.s0 ? cur : ~cur;
      else if (code.s2)
         return cur ^ prv;
      else if (code.s0)
         return cur & ~prv;
      else
         return prv & ~cur;
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         chain_q <= '0;
      else
         chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pad_sync,
   input  logic [NPINS-1:0]  istat,
   output logic [NPINS-1:0]  latch_q,
   output logic [NPINS-1:0]  dir_q,
   output logic [NPINS-1:0]  ien_q,
   output logic [NPINS-1:0]  sense0_q,
   output logic [NPINS-1:0]  sense1_q,
   output logic [NPINS-1:0]  sense2_q,
   output logic [NPINS-1:0]  istat_clr
);

   localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(OFS_VALUE);
   localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(OFS_DIR);
   localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(OFS_IEN);
   localparam logic [ADDR_W-1:0] A_SENSE0 = ADDR_W'(OFS_SENSE0);
   localparam logic [ADDR_W-1:0] A_SENSE1 = ADDR_W'(OFS_SENSE1);
   localparam logic [ADDR_W-1:0] A_SENSE2 = ADDR_W'(OFS_SENSE2);
   localparam logic [ADDR_W-1:0] A_ISTAT  = ADDR_W'(OFS_ISTAT);
   localparam logic [ADDR_W-1:0] A_LATCH  = ADDR_W'(OFS_LATCH);

   logic [NPINS-1:0] wpin;
   assign wpin = bus_wdata[NPINS-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q  <= '0;
         dir_q    <= '0;
         ien_q    <= '0;
         sense0_q <= '0;
         sense1_q <= '0;
         sense2_q <= '0;
      end else if (bus_we) begin
         case (bus_addr)
            A_VALUE:  latch_q  <= wpin;
            A_DIR:    dir_q    <= wpin;
            A_IEN:    ien_q    <= wpin;
            A_SENSE0: sense0_q <= wpin;
            A_SENSE1: sense1_q <= wpin;
            A_SENSE2: sense2_q <= wpin;
            default:  ;
         endcase
      end
   end

   assign istat_clr = (bus_we && bus_addr == A_ISTAT) ? wpin : '0;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_VALUE:  bus_rdata = BUS_W'(pad_sync);
         A_DIR:    bus_rdata = BUS_W'(dir_q);
         A_IEN:    bus_rdata = BUS_W'(ien_q);
         A_SENSE0: bus_rdata = BUS_W'(sense0_q);
         A_SENSE1: bus_rdata = BUS_W'(sense1_q);
         A_SENSE2: bus_rdata = BUS_W'(sense2_q);
         A_ISTAT:  bus_rdata = BUS_W'(istat);
         A_LATCH:  bus_rdata = BUS_W'(latch_q);
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pad_sync,
   input  logic [NPINS-1:0] ien,
   input  logic [NPINS-1:0] sense0,
   input  logic [NPINS-1:0] sense1,
   input  logic [NPINS-1:0] sense2,
   input  logic [NPINS-1:0] clr,
   output logic [NPINS-1:0] status,
   output logic             irq
);

   logic [NPINS-1:0] prev_q;
   logic [NPINS-1:0] hit;

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      sense_t code;
      assign code   = '{s2: sense2[i], s1: sense1[i], s0: sense0[i]};
      assign hit[i] = sense_hit(code, pad_sync[i], prev_q[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         status <= '0;
      end else begin
         prev_q <= pad_sync;
         // a new hit wins over a clear in the same cycle
         status <= (status & ~clr) | (hit & ien);
      end
   end

   assign irq = |(status & ien);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic              irq
);

   if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_npins
      $error("gpio_irq_bank: NPINS must be 1..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("gpio_irq_bank: ADDR_W must reach offset 0x1C");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_irq_bank: at least two synchronizer stages");
   end

   logic [NPINS-1:0] pad_sync;
   logic [NPINS-1:0] irq_status;
   logic [NPINS-1:0] irq_en;
   logic [NPINS-1:0] sense0, sense1, sense2;
   logic [NPINS-1:0] stat_clr;

   gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   gpio_ctrl_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_sync  (pad_sync),
      .istat     (irq_status),
      .latch_q   (pad_out),
      .dir_q     (pad_oe),
      .ien_q     (irq_en),
      .sense0_q  (sense0),
      .sense1_q  (sense1),
      .sense2_q  (sense2),
      .istat_clr (stat_clr)
   );

   gpio_irq_detect #(.NPINS(NPINS)) det_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pad_sync (pad_sync),
      .ien      (irq_en),
      .sense0   (sense0),
      .sense1   (sense1),
      .sense2   (sense2),
      .clr      (stat_clr),
      .status   (irq_status),
      .irq      (irq)
   );

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [NPINS-1:0]  pad_out,
   input logic [NPINS-1:0]  pad_oe,
   input logic              irq,
   input logic [NPINS-1:0]  irq_status,
   input logic [NPINS-1:0]  irq_en
);

   logic wr_val, wr_dir, wr_rb, wr_stat;
   assign wr_val  = bus_we && bus_addr == ADDR_W'(OFS_VALUE);
   assign wr_dir  = bus_we && bus_addr == ADDR_W'(OFS_DIR);
   assign wr_rb   = bus_we && bus_addr == ADDR_W'(OFS_LATCH);
   assign wr_stat = bus_we && bus_addr == ADDR_W'(OFS_ISTAT);

   AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_val |=> pad_out == $past(bus_wdata[NPINS-1:0])); // R2
   AST_READBACK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rb |=> $stable(pad_out)); // R2
   AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> pad_oe == $past(bus_wdata[NPINS-1:0])); // R3
   AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((irq_status & ~$past(irq_status) & ~$past(irq_en)) == '0)); // R7
   AST_W1C_KEEPS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat |=> ((irq_status & $past(irq_status & ~bus_wdata[NPINS-1:0]))
                   == $past(irq_status & ~bus_wdata[NPINS-1:0]))); // R8
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> ((irq_status & $past(irq_status)) == $past(irq_status))); // R8
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == '0 || irq_status == '0) |-> !irq); // R9

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;

   localparam int unsigned N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [N-1:0] pad_in = '0;
   logic [N-1:0] pad_out, pad_oe;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   gpio_irq_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   localparam logic [7:0] A_VAL = 8'h00, A_DIR = 8'h04, A_IEN = 8'h08,
      A_S0 = 8'h0C, A_S1 = 8'h10, A_S2 = 8'h14, A_ST = 8'h18, A_RB = 8'h1C;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // expected status from the requirement rules (R5, R6, R7)
   function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
         logic [31:0] t0, logic [31:0] t1, logic [31:0] t2, logic [31:0] m, bit cleared);
      logic [31:0] r = '0;
      for (int i = 0; i < 32; i++) begin
         if (t1[i]) begin
            logic la = t0[i] ? a[i] : ~a[i];
            logic lb = t0[i] ? b[i] : ~b[i];
            r[i] = cleared ? lb : (la | lb);
         end else if (cleared) r[i] = 1'b0;
         else if (t2[i]) r[i] = a[i] ^ b[i];
         else if (t0[i]) r[i] = ~a[i] & b[i];
         else r[i] = a[i] & ~b[i];
      end
      return r & m;
   endfunction

   task automatic run_case(string tag, logic [31:0] a, logic [31:0] b,
         logic [31:0] t0, logic [31:0] t1, logic [31:0] t2, logic [31:0] m);
      logic [31:0] got, e;
      wr(A_IEN, '0);
      pad_in = a;
      idle(4);
      wr(A_S0, t0); wr(A_S1, t1); wr(A_S2, t2);
      wr(A_IEN, m);
      wr(A_ST, 32'hFFFF_FFFF);
      idle(1);
      pad_in = b;
      idle(4);
      e = model(a, b, t0, t1, t2, m, 1'b0);
      rd(A_ST, got);
      check({tag, " status after transition"}, got, e);
      check({tag, " R9 irq"}, {31'd0, irq}, {31'd0, e != 0});
      wr(A_ST, 32'hFFFF_FFFF);
      idle(1);
      e = model(a, b, t0, t1, t2, m, 1'b1);
      rd(A_ST, got);
      check({tag, " R8 status after clear"}, got, e);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [2:0] codes [5] = '{3'b000, 3'b001, 3'b101, 3'b010, 3'b011};
      logic [31:0] pa [3] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5C3_0FF0};
      logic [31:0] pb [3] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h5AC3_F00F};
      logic [31:0] pm [3] = '{32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0F0F_0F0F};

      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(A_VAL, v); check("R1 value", v, 0);
      rd(A_DIR, v); check("R1 dir", v, 0);
      rd(A_IEN, v); check("R1 enable", v, 0);
      rd(A_S0, v);  check("R1 sense0", v, 0);
      rd(A_S1, v);  check("R1 sense1", v, 0);
      rd(A_S2, v);  check("R1 sense2", v, 0);
      rd(A_ST, v);  check("R1 status", v, 0);
      rd(A_RB, v);  check("R1 latch", v, 0);
      check("R1 pad_oe", pad_oe, 0);
      check("R1 irq", {31'd0, irq}, 0);

      // R2 latch and readback
      wr(A_VAL, 32'hDEAD_BEEF);
      check("R2 pad_out", pad_out, 32'hDEAD_BEEF);
      rd(A_RB, v); check("R2 latch readback", v, 32'hDEAD_BEEF);
      wr(A_RB, 32'h1234_5678);
      check("R2 readback write ignored pad_out", pad_out, 32'hDEAD_BEEF);
      rd(A_RB, v); check("R2 readback write ignored", v, 32'hDEAD_BEEF);

      // R3 direction
      wr(A_DIR, 32'hF0F0_A5A5);
      check("R3 pad_oe", pad_oe, 32'hF0F0_A5A5);
      rd(A_DIR, v); check("R3 dir readback", v, 32'hF0F0_A5A5);

      // R4 synchronized pad read, even on output pins
      @(negedge clk);
      pad_in = 32'h3C3C_1234;
      rd(A_VAL, v); check("R4 one edge old value", v, 0);
      rd(A_VAL, v); check("R4 two edges new value", v, 32'h3C3C_1234);
      rd(A_VAL, v); check("R4 not the latch", v, 32'h3C3C_1234);

      // R5 enable and sense registers read back
      wr(A_IEN, 32'h1357_9BDF); rd(A_IEN, v); check("R5 enable readback", v, 32'h1357_9BDF);
      wr(A_S0, 32'h2468_ACE0);  rd(A_S0, v);  check("R5 sense0 readback", v, 32'h2468_ACE0);
      wr(A_S1, 32'h0F1E_2D3C);  rd(A_S1, v);  check("R5 sense1 readback", v, 32'h0F1E_2D3C);
      wr(A_S2, 32'hC3B2_A190);  rd(A_S2, v);  check("R5 sense2 readback", v, 32'hC3B2_A190);

      // R5 R6 R7 sweep of codes x transitions x enable masks
      for (int c = 0; c < 5; c++) begin
         for (int p = 0; p < 3; p++) begin
            logic [31:0] t0 = {32{codes[c][0]}};
            logic [31:0] t1 = {32{codes[c][1]}};
            logic [31:0] t2 = {32{codes[c][2]}};
            run_case($sformatf("R5 R6 R7 code %03b pair %0d", codes[c], p),
                     pa[p], pb[p], t0, t1, t2, pm[p]);
         end
      end

      // per-pin mixed codes, including the unnamed ones
      run_case("R5 R6 mixed codes", 32'hA5C3_0FF0, 32'h5AC3_F00F,
               32'h3333_3333, 32'h0F0F_0F0F, 32'h00FF_00FF, 32'hFFFF_FFFF);

      // R8 partial clear, then R7 R9 enable removed
      run_case("R8 rise setup", 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF);
      pad_in = 32'h0;
      wr(A_S0, 32'hFFFF_FFFF);
      idle(4);
      pad_in = 32'hFFFF_FFFF;
      idle(4);
      rd(A_ST, v); check("R8 rise set all", v, 32'hFFFF_FFFF);
      wr(A_ST, 32'h0);
      rd(A_ST, v); check("R8 write zero keeps", v, 32'hFFFF_FFFF);
      wr(A_ST, 32'h0000_FFFF);
      rd(A_ST, v); check("R8 partial clear", v, 32'hFFFF_0000);
      check("R9 irq set", {31'd0, irq}, 1);
      wr(A_IEN, 32'h0000_FFFF);
      check("R9 irq masked", {31'd0, irq}, 0);
      rd(A_ST, v); check("R7 status kept after disable", v, 32'hFFFF_0000);
      pad_in = 32'h0;
      idle(4);
      pad_in = 32'hFFFF_FFFF;
      idle(4);
      rd(A_ST, v); check("R7 new rise only on enabled pins", v, 32'hFFFF_FFFF);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule